// File: doc/BRIEF.md
# Multi-format audio serial frame transmitter

This block is the timing engine of a transmit-only serial audio port. It watches an externally supplied bit clock, which it oversamples with its own faster system clock, and on every bit-clock launch edge it advances a frame position counter. From that position it drives a frame sync line and a serial data line. Five framings share the one core. They are a half-frame "I2S" style, left-aligned half-frame, right-aligned half-frame, and two short-pulse "DSP" framings. The framings differ only in sync width, sync polarity, a one-bit data lag, and where the second group of slots begins.

Sample words arrive on a valid/ready input, one word per slot, in slot order. A single staging register holds the next word. Configuration inputs are checked all the time. An illegal combination raises an error flag, parks the frame counter at the start of the frame, and holds both serial lines low until the configuration is made legal again.

Top module: `afmt_tx`

## Requirements
- R1: A frame lasts cfg_frame_len bit periods, and position 0 follows position cfg_frame_len-1. The sync line is in its asserted phase for positions below the sync length and in the other phase for the rest, so the frame start edge falls at position 0.
- R2: Format code 0 (I2S style) drives sync low for positions 0 to floor(len/2)-1 and high for the rest. The frame starts on the falling sync edge. Data lags its slot by one bit period.
- R3: Format code 1 (left aligned) drives sync high for the first floor(len/2) positions. The frame starts on the rising edge. There is no data lag.
- R4: Format code 2 (right aligned) has no lag and places each sample at offset slot_bits-data_bits inside its slot, so the sample ends on the slot's last bit. An odd frame length is a configuration error in this format.
- R5: Format codes 3 and 4 drive sync high for position 0 only. Code 3 lags data by one bit period, so the final bit of a full frame lands on position 0 of the next frame. Code 4 has no lag.
- R6: In codes 3 and 4, slot k begins at position k*slot_bits. In codes 0 to 2, slots 0 to S/2-1 begin at position 0 and slots S/2 to S-1 begin at position floor(len/2), each slot slot_bits long. A word is sent MSB first from bits data_bits-1 down to 0. Every other position carries 0.
- R7: The error flag is high when any of these holds: format code 5, 6 or 7; data_bits of zero or greater than slot_bits or the word width; slot_bits or the slot count zero; an odd slot count in codes 0 to 2; frame length below 2; or the slots not fitting in the frame (or in half the frame for codes 0 to 2).
- R8: While the error flag is high, fs_o and sd_o are 0 and word_ready_o is 0. When the configuration becomes legal, the next launch edge sends position 0 of a fresh frame.
- R9: With cfg_bclk_inv at 0 the outputs change only after a falling edge of bclk_i, for a receiver that samples on the rising edge. With cfg_bclk_inv at 1 they change only after a rising edge.
- R10: cfg_fs_inv at 1 inverts the sync line, which moves the frame start to the opposite sync edge.
- R11: Each slot takes the next word accepted on the valid/ready input, in slot order 0 to S-1, frame after frame. A slot that starts while no word is staged sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bit clock level, oversampled |
| cfg_frame_len | input | CNT_W | Frame length in bit periods |
| cfg_slot_bits | input | SB_W | Slot width in bits |
| cfg_data_bits | input | SB_W | Sample length in bits |
| cfg_slots | input | NS_W | Slots per frame |
| cfg_fmt | input | 3 | Framing code 0 to 4 |
| cfg_bclk_inv | input | 1 | Selects the launch edge of bclk_i |
| cfg_fs_inv | input | 1 | Inverts the frame sync polarity |
| word_i | input | DW | Sample word, right aligned |
| word_valid_i | input | 1 | Sample word valid |
| word_ready_o | output | 1 | Staging register empty |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| cfg_err_o | output | 1 | Illegal configuration |

## Verification
The hardest case to reach is the lagged short-pulse framing with slots that fill the frame exactly. There, the last bit of a frame must come out at position 0 of the following frame, carried over from the previous slot. A table vector sets slots times slot width equal to the frame length and runs several frames back to back, so that the carried bit is checked at each frame boundary. A second hard case is recovery without reset. The bench applies an illegal right-aligned length, confirms the lines stay idle across many bit periods, and then corrects the length so that the first frame must start at position 0. A run with the word source switched off shows that unfed slots send zeros.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

  localparam logic [2:0] FMT_I2S   = 3'd0;
  localparam logic [2:0] FMT_LEFT  = 3'd1;
  localparam logic [2:0] FMT_RIGHT = 3'd2;
  localparam logic [2:0] FMT_DSP_A = 3'd3;
  localparam logic [2:0] FMT_DSP_B = 3'd4;

  typedef struct packed {
    logic half;        // slots split across two half frames
    logic lag1;        // data lags its slot by one bit period
    logic start_fall;  // sync asserted phase is driven low
  } frame_flags_t;

endpackage

// File: rtl/afmt_bclk.sv
module afmt_bclk #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic launch_rise,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SYNC_STAGES:0]   chain;
  logic                   last_q, lvl, rise, fall;

  assign chain = {sync_q, bclk_i};
  assign lvl   = chain[SYNC_STAGES];

  always_comb begin
    sync_d = chain[SYNC_STAGES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= lvl;
    end
  end

  assign rise = lvl & ~last_q;
  assign fall = ~lvl & last_q;
  assign tick = launch_rise ? rise : fall;

  // R9
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/afmt_cfg.sv
module afmt_cfg
  import afmt_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int SB_W  = 6,
  parameter int NS_W  = 4,
  parameter int DW    = 32
) (
  input  logic [CNT_W-1:0] frame_len,
  input  logic [SB_W-1:0]  slot_bits,
  input  logic [SB_W-1:0]  data_bits,
  input  logic [NS_W-1:0]  slots,
  input  logic [2:0]       fmt,
  input  logic             fs_inv,
  output logic             err,
  output frame_flags_t     flags,
  output logic [CNT_W-1:0] half_pt,
  output logic [CNT_W-1:0] sync_len,
  output logic [NS_W-1:0]  half_slots,
  output logic [SB_W-1:0]  rj_off
);

  localparam int PW = NS_W + SB_W;
  localparam int CW = (PW > CNT_W) ? PW + 1 : CNT_W + 1;
  localparam logic [SB_W:0] DW_C = (SB_W+1)'(DW);

  logic          half_fmt, dsp_fmt;
  logic [PW-1:0] span;
  logic [CW-1:0] span_x, room_x;

  always_comb begin
    half_fmt   = (fmt == FMT_I2S) || (fmt == FMT_LEFT) || (fmt == FMT_RIGHT);
    dsp_fmt    = (fmt == FMT_DSP_A) || (fmt == FMT_DSP_B);
    half_pt    = frame_len >> 1;
    half_slots = slots >> 1;

    flags.half       = half_fmt;
    flags.lag1       = (fmt == FMT_I2S) || (fmt == FMT_DSP_A);
    flags.start_fall = (fmt == FMT_I2S) ^ fs_inv;

    sync_len = half_fmt ? half_pt : CNT_W'(1);
    rj_off   = (fmt == FMT_RIGHT) ? (slot_bits - data_bits) : '0;

    span   = PW'(half_fmt ? half_slots : slots) * PW'(slot_bits);
    span_x = CW'(span);
    room_x = half_fmt ? CW'(half_pt) : CW'(frame_len);

    err = !(half_fmt || dsp_fmt)
        || (data_bits == '0)
        || (slot_bits == '0)
        || (slots == '0)
        || (data_bits > slot_bits)
        || ({1'b0, data_bits} > DW_C)
        || (half_fmt && slots[0])
        || ((fmt == FMT_RIGHT) && frame_len[0])
        || (frame_len < CNT_W'(2))
        || (span_x > room_x);
  end

endmodule

// File: rtl/afmt_seq.sv
module afmt_seq #(
  parameter int CNT_W = 9,
  parameter int SB_W  = 6,
  parameter int NS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             err,
  input  logic             half,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] half_pt,
  input  logic [SB_W-1:0]  slot_bits,
  input  logic [NS_W-1:0]  slots,
  input  logic [NS_W-1:0]  half_slots,
  output logic [CNT_W-1:0] pos,
  output logic [SB_W-1:0]  bit_in_slot,
  output logic             slot_live
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nx;
  logic [SB_W-1:0]  bis_q, bis_d;
  logic [NS_W-1:0]  slot_q, slot_d;
  logic             step_en;

  assign step_en = tick | err;

  always_comb begin
    cnt_nx = (cnt_q >= frame_len - 1'b1) ? '0 : cnt_q + 1'b1;
    cnt_d  = cnt_q;
    bis_d  = bis_q;
    slot_d = slot_q;
    if (err) begin
      cnt_d  = '0;
      bis_d  = '0;
      slot_d = '0;
    end else if (tick) begin
      cnt_d = cnt_nx;
      if (cnt_nx == '0) begin
        bis_d  = '0;
        slot_d = '0;
      end else if (half && (cnt_nx == half_pt)) begin
        bis_d  = '0;
        slot_d = half_slots;
      end else if (bis_q == slot_bits - 1'b1) begin
        bis_d = '0;
        if (slot_q != '1) slot_d = slot_q + 1'b1;
      end else begin
        bis_d = bis_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bis_q  <= '0;
      slot_q <= '0;
    end else if (step_en) begin
      cnt_q  <= cnt_d;
      bis_q  <= bis_d;
      slot_q <= slot_d;
    end
  end

  always_comb begin
    if (half && (cnt_q < half_pt)) slot_live = (slot_q < half_slots);
    else                           slot_live = (slot_q < slots);
  end

  assign pos         = cnt_q;
  assign bit_in_slot = bis_q;

  // R8
  err_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (cnt_q == '0 && slot_q == '0 && bis_q == '0));

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !err && cnt_q == frame_len - 1'b1) |=> (cnt_q == '0));

endmodule

// File: rtl/afmt_out.sv
module afmt_out
  import afmt_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int SB_W  = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             err,
  input  frame_flags_t     flags,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [SB_W-1:0]  bit_in_slot,
  input  logic             slot_live,
  input  logic [SB_W-1:0]  rj_off,
  input  logic [SB_W-1:0]  data_bits,
  input  logic [DW-1:0]    word_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  output logic             fs_o,
  output logic             sd_o
);

  logic [DW-1:0]   pend_q, pend_d, shreg_q, shreg_d, cur_word, staged;
  logic            pend_full_q, pend_full_d;
  logic            prev_q, prev_d, fs_q, fs_d, sd_q, sd_d;
  logic            at_start, accept, consume, in_data, raw, fs_raw;
  logic [SB_W-1:0] rel, idx;
  logic            line_en;

  assign word_ready_o = !pend_full_q && !err;
  assign accept       = word_valid_i && word_ready_o;
  assign at_start     = slot_live && (bit_in_slot == '0);
  assign staged       = pend_full_q ? pend_q : '0;
  assign consume      = tick && !err && at_start;
  assign line_en      = tick | err;

  always_comb begin
    cur_word = at_start ? staged : shreg_q;
    rel      = bit_in_slot - rj_off;
    idx      = data_bits - 1'b1 - rel;
    in_data  = slot_live && (bit_in_slot >= rj_off) && (rel < data_bits);
    raw      = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (in_data && (idx == SB_W'(i))) raw = cur_word[i];
    end
    fs_raw = (pos < sync_len) ^ flags.start_fall;
  end

  always_comb begin
    fs_d        = fs_q;
    sd_d        = sd_q;
    prev_d      = prev_q;
    shreg_d     = shreg_q;
    if (err) begin
      fs_d   = 1'b0;
      sd_d   = 1'b0;
      prev_d = 1'b0;
    end else if (tick) begin
      fs_d   = fs_raw;
      sd_d   = flags.lag1 ? prev_q : raw;
      prev_d = raw;
      if (at_start) shreg_d = staged;
    end
    pend_full_d = err ? 1'b0 : ((pend_full_q & ~consume) | accept);
    pend_d      = accept ? word_i : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      sd_q    <= 1'b0;
      prev_q  <= 1'b0;
      shreg_q <= '0;
    end else if (line_en) begin
      fs_q    <= fs_d;
      sd_q    <= sd_d;
      prev_q  <= prev_d;
      shreg_q <= shreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full_q <= 1'b0;
      pend_q      <= '0;
    end else begin
      pend_full_q <= pend_full_d;
      pend_q      <= pend_d;
    end
  end

  assign fs_o = fs_q;
  assign sd_o = sd_q;

  // R8
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!fs_o && !sd_o));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !err) |=> ($stable(fs_o) && $stable(sd_o)));

  // R11
  stage_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_ready_o) |=> !word_ready_o);

endmodule

// File: rtl/afmt_tx.sv
module afmt_tx
  import afmt_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int SB_W        = 6,
  parameter int NS_W        = 4,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic [CNT_W-1:0] cfg_frame_len,
  input  logic [SB_W-1:0]  cfg_slot_bits,
  input  logic [SB_W-1:0]  cfg_data_bits,
  input  logic [NS_W-1:0]  cfg_slots,
  input  logic [2:0]       cfg_fmt,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_fs_inv,
  input  logic [DW-1:0]    word_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  output logic             fs_o,
  output logic             sd_o,
  output logic             cfg_err_o
);

  logic             tick, err, slot_live;
  frame_flags_t     flags;
  logic [CNT_W-1:0] half_pt, sync_len, pos;
  logic [NS_W-1:0]  half_slots;
  logic [SB_W-1:0]  rj_off, bit_in_slot;

  afmt_bclk #(.SYNC_STAGES(SYNC_STAGES)) u_bclk (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i),
    .launch_rise(cfg_bclk_inv), .tick(tick)
  );

  afmt_cfg #(.CNT_W(CNT_W), .SB_W(SB_W), .NS_W(NS_W), .DW(DW)) u_cfg (
    .frame_len(cfg_frame_len), .slot_bits(cfg_slot_bits),
    .data_bits(cfg_data_bits), .slots(cfg_slots), .fmt(cfg_fmt),
    .fs_inv(cfg_fs_inv), .err(err), .flags(flags), .half_pt(half_pt),
    .sync_len(sync_len), .half_slots(half_slots), .rj_off(rj_off)
  );

  afmt_seq #(.CNT_W(CNT_W), .SB_W(SB_W), .NS_W(NS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .err(err), .half(flags.half),
    .frame_len(cfg_frame_len), .half_pt(half_pt), .slot_bits(cfg_slot_bits),
    .slots(cfg_slots), .half_slots(half_slots), .pos(pos),
    .bit_in_slot(bit_in_slot), .slot_live(slot_live)
  );

  afmt_out #(.CNT_W(CNT_W), .SB_W(SB_W), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .err(err), .flags(flags),
    .pos(pos), .sync_len(sync_len), .bit_in_slot(bit_in_slot),
    .slot_live(slot_live), .rj_off(rj_off), .data_bits(cfg_data_bits),
    .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .fs_o(fs_o), .sd_o(sd_o)
  );

  assign cfg_err_o = err;

endmodule

// File: tb/afmt_tx_tb.sv
`timescale 1ns/1ps
module afmt_tx_tb;

  localparam int HP = 6;
  localparam int NV = 14;
  // fields: fmt[31:29] len[28:20] slot_bits[19:14] data_bits[13:8] slots[7:4] binv[3] finv[2] err[1]
  localparam logic [31:0] VT [NV] = '{
    {3'd0, 9'd64, 6'd32, 6'd24, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd0, 9'd32, 6'd16, 6'd16, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd1, 9'd48, 6'd24, 6'd20, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 9'd64, 6'd32, 6'd18, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd3, 9'd32, 6'd8,  6'd8,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd4, 9'd40, 6'd8,  6'd6,  4'd4, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd0, 9'd66, 6'd16, 6'd12, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd2, 9'd33, 6'd16, 6'd16, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd1, 9'd64, 6'd16, 6'd16, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd3, 9'd32, 6'd16, 6'd20, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd5, 9'd32, 6'd16, 6'd16, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd4, 9'd40, 6'd16, 6'd8,  4'd4, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd2, 9'd32, 6'd16, 6'd16, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd0, 9'd31, 6'd12, 6'd10, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_i = 1'b1;
  logic [8:0]  cfg_frame_len = 9'd64;
  logic [5:0]  cfg_slot_bits = 6'd32;
  logic [5:0]  cfg_data_bits = 6'd24;
  logic [3:0]  cfg_slots = 4'd2;
  logic [2:0]  cfg_fmt = 3'd0;
  logic        cfg_bclk_inv = 1'b0;
  logic        cfg_fs_inv = 1'b0;
  logic [31:0] word_i;
  logic        word_valid_i;
  logic        word_ready_o, fs_o, sd_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  logic feed_en = 1'b0;
  int widx;
  logic last_rdy;
  int m_fmt, m_fl, m_sb, m_dl, m_s, m_fi, m_fed;

  always #4 clk = ~clk;

  afmt_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .cfg_frame_len(cfg_frame_len),
    .cfg_slot_bits(cfg_slot_bits), .cfg_data_bits(cfg_data_bits),
    .cfg_slots(cfg_slots), .cfg_fmt(cfg_fmt), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_fs_inv(cfg_fs_inv), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .fs_o(fs_o), .sd_o(sd_o), .cfg_err_o(cfg_err_o)
  );

  function automatic logic [31:0] wgen(int n);
    return (32'(n) * 32'h9E37_79B9) ^ 32'h5A0F_C3E1;
  endfunction

  // word source: one new word after every accepted one (R11)
  initial begin
    widx = 0; word_valid_i = 1'b0; word_i = '0; last_rdy = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (!feed_en) begin
        widx = 0; word_valid_i = 1'b0; last_rdy = 1'b0;
      end else begin
        if (word_valid_i && last_rdy) widx++;
        word_valid_i = 1'b1;
        word_i = wgen(widx);
        last_rdy = word_ready_o;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int raw_bit(int q);
    int fr, p, rel, sl, b, slot, o, hp;
    logic [31:0] w;
    fr = q / m_fl; p = q % m_fl;
    if (m_fmt <= 2) begin
      hp = m_fl / 2;
      if (p >= hp) begin rel = p - hp; slot = m_s / 2; end
      else begin rel = p; slot = 0; end
      sl = rel / m_sb; b = rel % m_sb;
      if (sl >= m_s / 2) return 0;
      slot = slot + sl;
    end else begin
      sl = p / m_sb; b = p % m_sb;
      if (sl >= m_s) return 0;
      slot = sl;
    end
    o = (m_fmt == 2) ? m_sb - m_dl : 0;
    if (b < o || b >= o + m_dl) return 0;
    w = (m_fed != 0) ? wgen(fr * m_s + slot) : 32'd0;
    return int'(w[m_dl - 1 - (b - o)]);
  endfunction

  function automatic int exp_sd(int q);
    if (m_fmt == 0 || m_fmt == 3) return (q == 0) ? 0 : raw_bit(q - 1);
    return raw_bit(q);
  endfunction

  function automatic int exp_fs(int q);
    int p, sl, act, fall;
    p = q % m_fl;
    sl = (m_fmt <= 2) ? m_fl / 2 : 1;
    act = (p < sl) ? 1 : 0;
    fall = ((m_fmt == 0) ? 1 : 0) ^ m_fi;
    return act ^ fall;
  endfunction

  function automatic string ftag(int fmt);
    case (fmt)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_cfg(input int fmt, input int fl, input int sb, input int dl,
                         input int s, input int bi, input int fi, input int xerr,
                         input int nfr, input int fed, input int do_rst);
    string fst;
    feed_en = 1'b0;
    repeat (2) @(negedge clk);
    if (do_rst != 0) rst_n = 1'b0;
    m_fmt = fmt; m_fl = fl; m_sb = sb; m_dl = dl; m_s = s; m_fi = fi; m_fed = fed;
    cfg_fmt = 3'(fmt); cfg_frame_len = 9'(fl); cfg_slot_bits = 6'(sb);
    cfg_data_bits = 6'(dl); cfg_slots = 4'(s);
    cfg_bclk_inv = bi[0]; cfg_fs_inv = fi[0];
    bclk_i = ~bi[0];
    if (do_rst != 0) begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
    end
    @(negedge clk);
    feed_en = fed[0];
    repeat (4) @(negedge clk);
    chk(int'(cfg_err_o) == xerr, "R7 error flag", int'(cfg_err_o), xerr);
    if (xerr != 0) begin
      for (int k = 0; k < 8; k++) begin
        bclk_i = ~bclk_i; repeat (HP) @(negedge clk);
        chk(!fs_o && !sd_o, "R8 idle lines", int'({fs_o, sd_o}), 0);
        chk(!word_ready_o, "R8 ready low", int'(word_ready_o), 0);
        bclk_i = ~bclk_i; repeat (HP) @(negedge clk);
      end
    end else begin
      if (fi != 0)      fst = "R1/R10 sync";
      else if (bi != 0) fst = {"R1/R9/", ftag(fmt), " sync"};
      else              fst = {"R1/", ftag(fmt), " sync"};
      for (int q = 0; q < nfr * fl; q++) begin
        bclk_i = ~bclk_i;
        repeat (HP) @(negedge clk);
        chk(int'(fs_o) == exp_fs(q), fst, int'(fs_o), exp_fs(q));
        chk(int'(sd_o) == exp_sd(q),
            (fed != 0) ? {"R6/", ftag(fmt), " data"} : "R11 unfed slot",
            int'(sd_o), exp_sd(q));
        bclk_i = ~bclk_i;
        repeat (HP) @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // reset state: lines idle, one word can be staged (R8, R11)
    repeat (3) @(negedge clk);
    chk(!fs_o && !sd_o, "R8 reset lines", int'({fs_o, sd_o}), 0);
    chk(word_ready_o, "R11 reset ready", int'(word_ready_o), 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_cfg(int'(VT[v][31:29]), int'(VT[v][28:20]), int'(VT[v][19:14]),
              int'(VT[v][13:8]), int'(VT[v][7:4]), int'(VT[v][3]),
              int'(VT[v][2]), int'(VT[v][1]), 3, 1, 1);
    end

    // R8: illegal odd length, then corrected without reset; frame restarts at 0
    run_cfg(2, 33, 16, 12, 2, 0, 0, 1, 0, 1, 1);
    run_cfg(2, 32, 16, 12, 2, 0, 0, 0, 2, 1, 0);

    // R11: no words offered, every slot sends zeros
    run_cfg(4, 16, 8, 8, 2, 0, 0, 0, 2, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule